// File: doc/BRIEF.md
# Combining Fetch-and-Add Unit

This unit sits in front of one shared memory word and accepts requests from N processors. Each processor has a valid line, a two-bit opcode and a W-bit operand. The unit gathers every request that is present in one cycle into a batch. It then serves the batch atomically and answers each processor with its own result. A held request is always answered, even when it arrives while an earlier batch is still in progress.

Fetch-and-add and test-and-set requests in a batch are combined. They are put in order of ascending processor index, and each one receives the value the word would hold if the requests ahead of it had already been applied one by one. The word itself is written only once, with the final result. Reads and writes pass through unchanged. Writes in a batch take effect before any of the atomic operations.

Top module: `fa_combiner`

## Requirements
- R1: After reset the word holds 0, every response-valid bit is low, and the unit is ready to accept a batch in the first cycle after reset is released.
- R2: A lone fetch-and-add (opcode 2'b10) returns the word's previous value and leaves the word holding the previous value plus the operand.
- R3: Simultaneous fetch-and-adds are ordered by ascending processor index. Each one returns the starting value plus the operands of the lower-indexed requesters. The word ends holding the starting value plus all the operands.
- R4: All sums wrap modulo 2^W.
- R5: A test-and-set (opcode 2'b11) returns the running value and sets it to 1. In a batch of these, the first requester gets the old value and every later one gets 1.
- R6: A read (opcode 2'b00) returns the word as it was at the start of the batch and leaves the word unchanged. A write (opcode 2'b01) returns its own operand and stores it. When a batch holds several writes, the highest-indexed write is the one kept.
- R7: Writes in a batch are applied before its atomic operations, so the first atomic operation sees the written value.
- R8: A batch captured at a clock edge is answered two cycles later with a single-cycle response-valid pulse. The pulse is raised exactly for the captured requesters, and the returned values appear in the same cycle.
- R9: A request raised while a batch is in progress is not lost. It is captured in the first idle cycle after the response cycle, provided it is still held, and it sees the result of the earlier batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | N | Request valid, one bit per processor, held until answered |
| reqOp | input | 2*N | Opcode per processor, processor i at bits [2i+1:2i] |
| reqData | input | N*W | Operand per processor, processor i at bits [W*i+W-1:W*i] |
| rspValid | output | N | One-cycle response pulse per processor |
| rspData | output | N*W | Returned value per processor, valid with rspValid |

## Verification
A batch driven in an idle cycle is captured at the next edge. The response must be low in the execute cycle that follows. The response must be high, with the result data, in the cycle after that, and low again in the idle cycle after it. The bench steps one cycle at a time and samples at the falling edge. It compares response-valid against the expected mask in every cycle, and it compares data only in the response cycle. A request raised during the execute cycle is expected three cycles after the first response.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_FADD  = 2'b10,
    OP_TSET  = 2'b11
  } opE;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_EXEC = 2'b01,
    ST_RESP = 2'b10
  } stateE;

  typedef struct packed {
    logic capture;
    logic commit;
  } strobeT;
endpackage

// File: rtl/fa_ctrl.sv
module fa_ctrl
  import fa_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   anyReq,
  output strobeT strobe
);
  stateE state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (anyReq) state <= ST_EXEC;
        ST_EXEC: state <= ST_RESP;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = (state == ST_IDLE) && anyReq;
    strobe.commit  = (state == ST_EXEC);
  end
endmodule

// File: rtl/fa_dpath.sv
module fa_dpath
  import fa_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  strobeT         strobe,
  input  logic [N-1:0]   reqValid,
  input  logic [2*N-1:0] reqOp,
  input  logic [N*W-1:0] reqData,
  output logic [N-1:0]   rspValid,
  output logic [N*W-1:0] rspData
);
  localparam logic [W-1:0] SET_VAL = W'(1);

  logic [W-1:0] wordQ;
  logic [N-1:0] pendValid;
  opE           pendOp   [N];
  logic [W-1:0] pendData [N];
  logic [N-1:0] rspValidQ;
  logic [W-1:0] rspDataQ [N];

  logic [W-1:0] afterWr;
  logic [W-1:0] run      [N+1];
  logic [W-1:0] retVal   [N];

  // writes land first; the highest index write wins
  always_comb begin
    afterWr = wordQ;
    for (int i = 0; i < N; i++) begin
      if (pendValid[i] && pendOp[i] == OP_WRITE) afterWr = pendData[i];
    end
  end

  assign run[0] = afterWr;

  generate
    for (genvar g = 0; g < N; g++) begin : g_chain
      logic isFadd;
      logic isTset;
      assign isFadd = pendValid[g] && pendOp[g] == OP_FADD;
      assign isTset = pendValid[g] && pendOp[g] == OP_TSET;
      assign run[g+1] = isFadd ? run[g] + pendData[g] :
                        isTset ? SET_VAL : run[g];
      always_comb begin
        case (pendOp[g])
          OP_READ:  retVal[g] = wordQ;
          OP_WRITE: retVal[g] = pendData[g];
          default:  retVal[g] = run[g];
        endcase
      end
      assign rspData[g*W +: W] = rspDataQ[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wordQ     <= '0;
      pendValid <= '0;
      rspValidQ <= '0;
    end else begin
      rspValidQ <= '0;
      if (strobe.capture) begin
        pendValid <= reqValid;
      end else if (strobe.commit) begin
        wordQ     <= run[N];
        rspValidQ <= pendValid;
        pendValid <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (strobe.capture) begin
        pendOp[i]   <= opE'(reqOp[2*i +: 2]);
        pendData[i] <= reqData[W*i +: W];
      end
      if (strobe.commit) rspDataQ[i] <= retVal[i];
    end
  end

  assign rspValid = rspValidQ;
endmodule

// File: rtl/fa_combiner.sv
module fa_combiner
  import fa_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   reqValid,
  input  logic [2*N-1:0] reqOp,
  input  logic [N*W-1:0] reqData,
  output logic [N-1:0]   rspValid,
  output logic [N*W-1:0] rspData
);
  strobeT strobe;

  fa_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .anyReq (|reqValid),
    .strobe (strobe)
  );

  fa_dpath #(.N(N), .W(W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqData  (reqData),
    .rspValid (rspValid),
    .rspData  (rspData)
  );
endmodule

// File: rtl/fa_combiner_chk.sv
module fa_combiner_chk #(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   reqValid,
  input logic [2*N-1:0] reqOp,
  input logic [N*W-1:0] reqData,
  input logic [N-1:0]   rspValid,
  input logic [N*W-1:0] rspData
);
  // R8: only requesters seen two cycles earlier are answered
  a_r8_rsp_origin: assert property (@(posedge clk) disable iff (rst)
    (|rspValid) |-> ((rspValid & ~$past(reqValid, 2)) == '0));

  // R8: the response is a single-cycle pulse
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (rst)
    (|rspValid) |=> (rspValid == '0));

  // R9: the next batch cannot answer before idle and execute cycles pass
  a_r9_spacing: assert property (@(posedge clk) disable iff (rst)
    (|rspValid) |=> ##1 (rspValid == '0));

  generate
    for (genvar g = 0; g < N; g++) begin : g_lane
      // R6: a write is answered with its own operand
      a_r6_write_echo: assert property (@(posedge clk) disable iff (rst)
        (rspValid[g] && $past(reqOp[2*g +: 2], 2) == 2'b01)
          |-> (rspData[W*g +: W] == $past(reqData[W*g +: W], 2)));
    end
  endgenerate
endmodule

bind fa_combiner fa_combiner_chk #(.N(N), .W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqOp    (reqOp),
  .reqData  (reqData),
  .rspValid (rspValid),
  .rspData  (rspData)
);

// File: tb/sim_fa_combiner.sv
module sim_fa_combiner;
  localparam int N = 4;
  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   reqValid = '0;
  logic [2*N-1:0] reqOp = '0;
  logic [N*W-1:0] reqData = '0;
  logic [N-1:0]   rspValid;
  logic [N*W-1:0] rspData;

  int checks = 0;
  int errors = 0;
  int mWord = 0;

  logic [N-1:0] bV;
  logic [1:0]   bOp  [N];
  int           bDat [N];
  int           expD [N];

  always #5 clk = ~clk;

  fa_combiner #(.N(N), .W(W)) u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .reqData(reqData), .rspValid(rspValid), .rspData(rspData)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic stepCheck(input logic [N-1:0] expMask, input string tag);
    @(negedge clk);
    chk({tag, " rspValid"}, int'(rspValid), int'(expMask));
  endtask

  task automatic clearB();
    bV = '0;
    for (int i = 0; i < N; i++) begin bOp[i] = 2'b00; bDat[i] = 0; end
  endtask

  task automatic addReq(input int p, input logic [1:0] op, input int d);
    bV[p] = 1'b1; bOp[p] = op; bDat[p] = d;
  endtask

  // behavioural reference: reads see start value, writes next, atomics by index
  task automatic model();
    int run;
    run = mWord;
    for (int i = 0; i < N; i++)
      if (bV[i] && bOp[i] == 2'b01) run = bDat[i] & MASK;
    for (int i = 0; i < N; i++) begin
      if (!bV[i]) continue;
      case (bOp[i])
        2'b00: expD[i] = mWord;
        2'b01: expD[i] = bDat[i] & MASK;
        2'b10: begin expD[i] = run; run = (run + bDat[i]) & MASK; end
        default: begin expD[i] = run; run = 1; end
      endcase
    end
    mWord = run;
  endtask

  task automatic driveB();
    for (int i = 0; i < N; i++) begin
      reqValid[i]       = bV[i];
      reqOp[2*i +: 2]   = bOp[i];
      reqData[W*i +: W] = W'(bDat[i]);
    end
  endtask

  task automatic runBatch(input string tag);
    model();
    driveB();
    stepCheck('0, tag);
    stepCheck(bV, {tag, " R8"});
    for (int i = 0; i < N; i++)
      if (bV[i]) chk({tag, $sformatf(" p%0d data", i)}, int'(rspData[W*i +: W]), expD[i]);
    reqValid = '0;
    stepCheck('0, tag);
  endtask

  task automatic readWord(input string tag);
    clearB(); addReq(1, 2'b00, 0); runBatch({tag, " readback"});
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 rspValid after reset", int'(rspValid), 0);
    readWord("R1");

    // R2: single fetch-and-add
    clearB(); addReq(2, 2'b10, 5); runBatch("R2");
    readWord("R2");

    // R3: four simultaneous fetch-and-adds
    clearB();
    addReq(0, 2'b10, 1); addReq(1, 2'b10, 2);
    addReq(2, 2'b10, 3); addReq(3, 2'b10, 4);
    runBatch("R3");
    readWord("R3");

    // R4: wrap modulo 2^W
    clearB(); addReq(1, 2'b01, 250); runBatch("R4 setup");
    clearB(); addReq(0, 2'b10, 10); addReq(3, 2'b10, 3); runBatch("R4");
    readWord("R4");

    // R5: combined test-and-set
    clearB();
    addReq(1, 2'b11, 0); addReq(2, 2'b11, 0); addReq(3, 2'b11, 0);
    runBatch("R5");
    readWord("R5");
    clearB(); addReq(2, 2'b01, 0); runBatch("R5 clear");
    clearB(); addReq(0, 2'b11, 0); runBatch("R5 lone");
    readWord("R5");

    // R6 and R7: writes, read and atomic in one batch
    clearB();
    addReq(0, 2'b01, 20); addReq(1, 2'b00, 0);
    addReq(2, 2'b01, 30); addReq(3, 2'b10, 5);
    runBatch("R6 R7");
    readWord("R7");

    // R9: a request arriving mid-batch waits and sees the earlier result
    begin
      int w0;
      w0 = mWord;
      clearB(); addReq(0, 2'b10, 3); driveB();
      stepCheck('0, "R9 exec");
      reqValid[1] = 1'b1; reqOp[3:2] = 2'b10; reqData[2*W-1:W] = W'(4);
      stepCheck(4'b0001, "R9 first");
      chk("R9 p0 data", int'(rspData[W-1:0]), w0);
      reqValid[0] = 1'b0;
      stepCheck('0, "R9 idle");
      stepCheck('0, "R9 exec2");
      stepCheck(4'b0010, "R9 second");
      chk("R9 p1 data", int'(rspData[2*W-1:W]), (w0 + 3) & MASK);
      reqValid = '0;
      stepCheck('0, "R9 tail");
      mWord = (w0 + 7) & MASK;
      readWord("R9");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule